// File: doc/BRIEF.md
# Pipeline Opcode Control Decoder

This block is the main decoder in the instruction decode stage of a five-stage pipeline. It takes the 6-bit opcode field of the instruction held in the fetch/decode register. It produces nine control bits, split into three bundles: one for the write-back stage, one for the memory stage and one for the execute stage. The decode stage copies these bundles into the next pipeline register, and each later stage removes the bundle it uses.

The decoder recognises five opcodes: register-type arithmetic, load word, store word, branch-if-equal and a dedicated no-op. The no-op clears every control bit, so it behaves as a bubble. Any other opcode produces a safe pattern. In that pattern nothing writes registers or memory and nothing branches, and the ALU operation selector holds the reserved value 11 so that the ALU block can mark the result as invalid. Decoding of the ALU function field is left to the ALU block.

The block is purely combinational. Its outputs follow the opcode in the same cycle, with no clock and no reset.

Top module: `ctl_decoder`

## Requirements
- R1: The bundle bit layouts are fixed as follows. `wb_o` is {reg_write, mem_to_reg}, with reg_write at bit 1. `mem_o` is {branch, mem_read, mem_write}, with branch at bit 2. `ex_o` is {reg_dst, alu_op[1:0], alu_src}, with reg_dst at bit 3 and alu_src at bit 0.
- R2: Opcode 000000 (register-type) sets reg_write, reg_dst and alu_op=10, and clears every other bit: wb_o=10, mem_o=000, ex_o=1100.
- R3: Opcode 100011 (load word) sets reg_write, mem_to_reg, mem_read and alu_src, with alu_op=00: wb_o=11, mem_o=010, ex_o=0001.
- R4: Opcode 101011 (store word) sets mem_write and alu_src only, with alu_op=00: wb_o=00, mem_o=001, ex_o=0001.
- R5: Opcode 000100 (branch-if-equal) sets branch and alu_op=01 only: wb_o=00, mem_o=100, ex_o=0010.
- R6: Opcode 100000 (no-op) drives all nine control bits to zero.
- R7: Every opcode other than the five above gives alu_op=11 and all other bits zero: wb_o=00, mem_o=000, ex_o=0110.
- R8: The outputs are a combinational function of `op_i` alone. A new opcode shows its decode without any clock edge, and the same opcode always gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 6 | Opcode field of the instruction in the fetch/decode register |
| wb_o | output | 2 | Write-back control bundle {reg_write, mem_to_reg} |
| mem_o | output | 3 | Memory control bundle {branch, mem_read, mem_write} |
| ex_o | output | 4 | Execute control bundle {reg_dst, alu_op[1:0], alu_src} |

## Verification
The bench targets three weak points.

- **No-op against register-type.** The no-op opcode differs from the register-type opcode in a single bit. A decoder that matched only the low bits would turn the bubble into a register write, with reg_dst and alu_op=10 set.
- **Near-miss opcodes.** The bench applies opcodes one bit away from load, store and branch. A decoder that matched them loosely would raise mem_read, mem_write or branch on an undefined instruction.
- **Every undefined opcode.** The bench sweeps all 64 codes so that an undefined opcode cannot fall back to alu_op=00 or pass silently. It also changes the opcode between clock edges to show that the decode does not wait for a clock edge.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;
  localparam int unsigned OP_W    = 6;
  localparam int unsigned ALUOP_W = 2;

  typedef enum logic [2:0] {
    CLS_RTYPE,
    CLS_LOAD,
    CLS_STORE,
    CLS_BRANCH,
    CLS_NOP,
    CLS_BAD
  } op_class_e;

  typedef enum logic [ALUOP_W-1:0] {
    ALU_ADDR = 2'b00,
    ALU_CMP  = 2'b01,
    ALU_FUNC = 2'b10,
    ALU_BAD  = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic reg_write;
    logic mem_to_reg;
  } wb_ctl_t;

  typedef struct packed {
    logic branch;
    logic mem_read;
    logic mem_write;
  } mem_ctl_t;

  typedef struct packed {
    logic    reg_dst;
    alu_op_e alu_op;
    logic    alu_src;
  } ex_ctl_t;

  localparam int unsigned WB_W  = $bits(wb_ctl_t);
  localparam int unsigned MEM_W = $bits(mem_ctl_t);
  localparam int unsigned EX_W  = $bits(ex_ctl_t);
endpackage

// File: rtl/ctl_op_class.sv
module ctl_op_class
  import ctl_dec_pkg::*;
#(
  parameter int unsigned      W          = OP_W,
  parameter logic [W-1:0]     OPC_RTYPE  = 6'b000000,
  parameter logic [W-1:0]     OPC_LOAD   = 6'b100011,
  parameter logic [W-1:0]     OPC_STORE  = 6'b101011,
  parameter logic [W-1:0]     OPC_BRANCH = 6'b000100,
  parameter logic [W-1:0]     OPC_NOP    = 6'b100000
) (
  input  logic [W-1:0] op_i,
  output op_class_e    cls_o
);
  localparam int unsigned N_OPC = 5;
  localparam logic [N_OPC*W-1:0] OPC_TAB =
    {OPC_NOP, OPC_BRANCH, OPC_STORE, OPC_LOAD, OPC_RTYPE};

  logic [N_OPC-1:0] hit;

  // full-width compare per known opcode
  for (genvar g = 0; g < N_OPC; g++) begin : g_match
    assign hit[g] = (op_i == OPC_TAB[g*W +: W]);
  end

  always_comb begin
    unique case (1'b1)
      hit[0]:  cls_o = CLS_RTYPE;
      hit[1]:  cls_o = CLS_LOAD;
      hit[2]:  cls_o = CLS_STORE;
      hit[3]:  cls_o = CLS_BRANCH;
      hit[4]:  cls_o = CLS_NOP;
      default: cls_o = CLS_BAD;
    endcase
  end
endmodule

// File: rtl/ctl_field_gen.sv
module ctl_field_gen
  import ctl_dec_pkg::*;
(
  input  op_class_e cls_i,
  output wb_ctl_t   wb_o,
  output mem_ctl_t  mem_o,
  output ex_ctl_t   ex_o
);
  always_comb begin
    wb_o  = '0;
    mem_o = '0;
    ex_o  = '{reg_dst: 1'b0, alu_op: ALU_ADDR, alu_src: 1'b0};
    case (cls_i)
      CLS_RTYPE: begin
        wb_o.reg_write = 1'b1;
        ex_o.reg_dst   = 1'b1;
        ex_o.alu_op    = ALU_FUNC;
      end
      CLS_LOAD: begin
        wb_o.reg_write  = 1'b1;
        wb_o.mem_to_reg = 1'b1;
        mem_o.mem_read  = 1'b1;
        ex_o.alu_src    = 1'b1;
      end
      CLS_STORE: begin
        mem_o.mem_write = 1'b1;
        ex_o.alu_src    = 1'b1;
      end
      CLS_BRANCH: begin
        mem_o.branch = 1'b1;
        ex_o.alu_op  = ALU_CMP;
      end
      CLS_NOP: ;  // bubble: all zero
      default: ex_o.alu_op = ALU_BAD;  // safe: no state change
    endcase
  end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_dec_pkg::*;
#(
  parameter logic [OP_W-1:0] OPC_RTYPE  = 6'b000000,
  parameter logic [OP_W-1:0] OPC_LOAD   = 6'b100011,
  parameter logic [OP_W-1:0] OPC_STORE  = 6'b101011,
  parameter logic [OP_W-1:0] OPC_BRANCH = 6'b000100,
  parameter logic [OP_W-1:0] OPC_NOP    = 6'b100000
) (
  input  logic [OP_W-1:0]  op_i,
  output logic [WB_W-1:0]  wb_o,
  output logic [MEM_W-1:0] mem_o,
  output logic [EX_W-1:0]  ex_o
);
  op_class_e cls;
  wb_ctl_t   wb_s;
  mem_ctl_t  mem_s;
  ex_ctl_t   ex_s;

  ctl_op_class #(
    .W         (OP_W),
    .OPC_RTYPE (OPC_RTYPE),
    .OPC_LOAD  (OPC_LOAD),
    .OPC_STORE (OPC_STORE),
    .OPC_BRANCH(OPC_BRANCH),
    .OPC_NOP   (OPC_NOP)
  ) u_class (
    .op_i (op_i),
    .cls_o(cls)
  );

  ctl_field_gen u_fields (
    .cls_i(cls),
    .wb_o (wb_s),
    .mem_o(mem_s),
    .ex_o (ex_s)
  );

  assign wb_o  = wb_s;
  assign mem_o = mem_s;
  assign ex_o  = ex_s;
endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk (
  input logic [5:0] op_i,
  input logic [1:0] wb_o,
  input logic [2:0] mem_o,
  input logic [3:0] ex_o
);
  always_comb begin
    if (op_i == 6'b100000) begin
      p_nop_all_zero_r6: assert ({wb_o, mem_o, ex_o} == 9'b0);
    end
    if (op_i == 6'b000000) begin
      p_rtype_ctl_r2: assert ({wb_o, mem_o, ex_o} == 9'b10_000_1100);
    end
    if (op_i == 6'b100011) begin
      p_load_ctl_r3: assert ({wb_o, mem_o, ex_o} == 9'b11_010_0001);
    end
    if (op_i == 6'b101011) begin
      p_store_ctl_r4: assert ({wb_o, mem_o, ex_o} == 9'b00_001_0001);
    end
    if (op_i == 6'b000100) begin
      p_branch_ctl_r5: assert ({wb_o, mem_o, ex_o} == 9'b00_100_0010);
    end
    if (ex_o[2:1] == 2'b11) begin
      p_bad_no_side_effect_r7: assert (wb_o[1] == 1'b0 && mem_o == 3'b000);
    end
    // R1: a memory access is a read or a write, never both
    p_mem_excl_r1: assert (!(mem_o[1] && mem_o[0]));
  end
endmodule

bind ctl_decoder ctl_decoder_chk u_chk (
  .op_i (op_i),
  .wb_o (wb_o),
  .mem_o(mem_o),
  .ex_o (ex_o)
);

// File: tb/tb_ctl_decoder.sv
`timescale 1ns/1ps
module tb_ctl_decoder;
  logic       clk;
  logic       rst_ni;
  logic [5:0] op_i;
  logic [1:0] wb_o;
  logic [2:0] mem_o;
  logic [3:0] ex_o;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  ctl_decoder dut (.op_i(op_i), .wb_o(wb_o), .mem_o(mem_o), .ex_o(ex_o));

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input string req, input logic [5:0] op,
                       input logic [8:0] exp);
    logic [8:0] act;
    act = {wb_o, mem_o, ex_o};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b actual=%b expected=%b", req, op, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] op);
    @(negedge clk);
    op_i = op;
    #5;
  endtask

  function automatic bit known(input logic [5:0] op);
    return op == 6'b000000 || op == 6'b100011 || op == 6'b101011 ||
           op == 6'b000100 || op == 6'b100000;
  endfunction

  task automatic t_reset_state();
    @(posedge clk);
    #5;
    check("R6 initial no-op", op_i, 9'b00_000_0000);
  endtask

  task automatic t_known();
    apply(6'b000000); check("R2 rtype", op_i, 9'b10_000_1100);
    apply(6'b100011); check("R3 load", op_i, 9'b11_010_0001);
    apply(6'b101011); check("R4 store", op_i, 9'b00_001_0001);
    apply(6'b000100); check("R5 branch", op_i, 9'b00_100_0010);
    apply(6'b100000); check("R6 nop", op_i, 9'b00_000_0000);
  endtask

  task automatic t_layout_r1();
    // individual bits: reg_write=wb[1], mem_read=mem[1], alu_src=ex[0]
    apply(6'b100011);
    n_run++;
    if (wb_o[1] !== 1'b1 || wb_o[0] !== 1'b1 || mem_o[1] !== 1'b1 ||
        ex_o[0] !== 1'b1 || ex_o[3] !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 layout actual=%b_%b_%b expected=11_010_0001",
               wb_o, mem_o, ex_o);
    end
  endtask

  task automatic t_near_miss();
    apply(6'b100001); check("R7 near nop", op_i, 9'b00_000_0110);
    apply(6'b100010); check("R7 near load", op_i, 9'b00_000_0110);
    apply(6'b101010); check("R7 near store", op_i, 9'b00_000_0110);
    apply(6'b000101); check("R7 near branch", op_i, 9'b00_000_0110);
    apply(6'b111111); check("R7 all ones", op_i, 9'b00_000_0110);
  endtask

  task automatic t_sweep_r7();
    for (int k = 0; k < 64; k++) begin
      if (!known(6'(k))) begin
        apply(6'(k));
        check("R7 sweep", op_i, 9'b00_000_0110);
      end
    end
  endtask

  task automatic t_comb_r8();
    // change opcode mid-cycle, away from any edge
    @(posedge clk);
    #3 op_i = 6'b000100;
    #2 check("R8 comb branch", op_i, 9'b00_100_0010);
    op_i = 6'b000000;
    #2 check("R8 comb rtype", op_i, 9'b10_000_1100);
    op_i = 6'b000100;
    #2 check("R8 repeat branch", op_i, 9'b00_100_0010);
  endtask

  initial begin
    rst_ni = 1'b0;
    op_i   = 6'b100000;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_known();
    t_layout_r1();
    t_near_miss();
    t_sweep_r7();
    t_comb_r8();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule